// File: doc/BRIEF.md
# Four-Event Timestamp Capture Unit

This peripheral timestamps edges on a single input line. A 32-bit counter advances once per clock while its run control is set. Each detected edge copies the counter into one of four capture slots. The slots fill in a rotating order. Each slot has its own edge-polarity bit, so alternate slots can watch rising and falling edges. This lets software measure pulse widths and periods from the differences between slots.

A small word-addressed bus gives software read and write access to the counter, the four slots and the control word. It also reaches an interrupt enable/flag word and a write-one-to-clear word.

Five event sources set their own sticky flags: the four captures and a counter wrap. A single interrupt line reflects a global latch. The latch is set by any enabled flag that rises and stays set until software clears it.

The sequencer is an explicit state machine with two named states:
- **SEQ_ARMED**: edges are accepted. The slot pointer moves to the next slot on each capture. When the pointer reaches the stop index it returns to slot 0. In continuous mode the machine stays in SEQ_ARMED (transition *wrap*). In one-shot mode it moves to SEQ_HALTED (transition *finish*).
- **SEQ_HALTED**: all edges are ignored. A re-arm strobe moves the machine back to SEQ_ARMED with the pointer at slot 0 (transition *rearm*). A re-arm strobe in SEQ_ARMED also puts the pointer back at slot 0.

Top module: `stamp_capture`

## Requirements
- R1: Counter access and counting. The counter register is at byte offset 0x00 and can be read and written. It counts up by one per clock only while control bit 20 is 1, and it wraps from 0xFFFFFFFF to 0. A software write to it takes priority over the increment.
- R2: Wrap event. A wrap of the running counter sets the event-4 flag, which is bit 21 of offset 0x2C.
- R3: Capture load. Capture slot i is at offset 0x08+4*i. On an accepted edge, the slot selected by the pointer takes the value the counter holds in the cycle the edge is detected, and the pointer advances. The input passes through two synchronizing flops before edge detection.
- R4: Polarity. Control bit 2*i selects the edge for slot i: 0 means rising, 1 means falling. An edge of the other direction leaves the slot unchanged and does not move the pointer.
- R5: Load enable. While control bit 8 is 0, no slot is loaded by an input edge.
- R6: Continuous mode. With control bit 16 at 0 and stop index 3 in bits 18:17, slots fill in the order 0,1,2,3 and then start again at 0.
- R7: One-shot mode and re-arm. With control bit 16 at 1, loading stops after the slot equal to the stop index has been loaded. Writing 1 to control bit 19 re-arms the sequence at slot 0. Bit 19 always reads back as 0.
- R8: Enable and flag word at 0x2C. Event i has its enable at bit i+1 (read/write) and its flag at bit i+17 (read-only). Flags set whether or not they are enabled.
- R9: Clear word at 0x30, write-one-to-clear. Bit 0 clears the global latch and bit i+1 clears flag i. If a new event for a flag or for the latch arrives in the same cycle as its clear, the set wins.
- R10: Interrupt. The interrupt output equals the global latch. The latch sets when a flag whose enable is 1 goes from 0 to 1. It stays set after the flag is cleared, until bit 0 of 0x30 is written.
- R11: Reset and unmapped reads. After reset every register is 0, the counter is stopped and the interrupt is low. Reads of unmapped offsets return 0.
- R12: Software can write the capture slots, and the written value reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; also the counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access, 0 otherwise |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt, high while the global latch is set |

## Verification
Two collisions are provoked on purpose:
- **Clear against capture.** The bench schedules a software clear of a capture flag and of the global latch so that its write edge is the same clock edge on which a synchronized input edge loads that slot. It does this by counting the two synchronizer flops and the edge register from the moment the input changes. It then expects the flag and the interrupt to be still set, and the slot to hold the new timestamp, because the set wins.
- **Write against count.** The bench writes the counter while it is stopped and starts it, then checks the exact values read one and three cycles later.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

    localparam int CNT_W  = 32;
    localparam int NCAP   = 4;
    localparam int IDX_W  = $clog2(NCAP);
    localparam int NEVT   = NCAP + 1;
    localparam int ADDR_W = 8;

    // register offsets (software-visible map)
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CAP0 = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_IEF  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h30;

    // control word fields
    localparam int CB_LOAD    = 8;
    localparam int CB_ONESHOT = 16;
    localparam int CB_STOP_LO = 17;
    localparam int CB_REARM   = 19;
    localparam int CB_RUN     = 20;

    // enable / flag word fields
    localparam int EN_LO   = 1;
    localparam int FLAG_LO = 17;

    typedef enum logic {
        SEQ_ARMED,
        SEQ_HALTED
    } seq_state_t;

    function automatic logic [31:0] ctrl_wmask();
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < NCAP; i++) m[2*i] = 1'b1;
        m[CB_LOAD]               = 1'b1;
        m[CB_ONESHOT]            = 1'b1;
        m[CB_STOP_LO +: IDX_W]   = '1;
        m[CB_RUN]                = 1'b1;
        return m;
    endfunction

    localparam logic [31:0] CTRL_MASK = ctrl_wmask();

endpackage

// File: rtl/stamp_edge_sync.sv
module stamp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/stamp_seq.sv
module stamp_seq
    import stamp_pkg::*;
#(
    parameter int N   = NCAP,
    parameter int IW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          fall,
    input  logic [N-1:0]  pol,
    input  logic          ld_en,
    input  logic          oneshot,
    input  logic [IW-1:0] stop_idx,
    input  logic          rearm,
    output logic          fire,
    output logic [IW-1:0] idx,
    output logic          halted
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    seq_state_t    state_q, state_d;
    logic [IW-1:0] ptr_q, ptr_d;
    logic          hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_ARMED;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        hit    = pol[ptr_q] ? fall : rise;
        fire   = (state_q == SEQ_ARMED) && ld_en && hit;
        idx    = ptr_q;
        halted = (state_q == SEQ_HALTED);
    end

    // transitions
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            SEQ_ARMED: begin
                if (fire) begin
                    if (ptr_q == stop_idx || ptr_q == LAST) begin
                        ptr_d = '0;                        // wrap / finish
                        if (oneshot) state_d = SEQ_HALTED;
                    end else begin
                        ptr_d = ptr_q + 1'b1;
                    end
                end
                if (rearm) ptr_d = '0;
            end
            SEQ_HALTED: begin
                if (rearm) begin                           // rearm
                    state_d = SEQ_ARMED;
                    ptr_d   = '0;
                end
            end
        endcase
    end
endmodule

// File: rtl/stamp_irq.sv
module stamp_irq #(
    parameter int NE = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] evt,
    input  logic [NE-1:0] en,
    input  logic [NE-1:0] clr_flags,
    input  logic          clr_glb,
    output logic [NE-1:0] flags,
    output logic          irq
);
    logic [NE-1:0] flags_q;
    logic          glb_q;
    logic [NE-1:0] newly;

    assign newly = evt & ~flags_q & en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            glb_q   <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_flags) | evt;
            glb_q   <= (glb_q & ~clr_glb) | (|newly);
        end
    end

    assign flags = flags_q;
    assign irq   = glb_q;
endmodule

// File: rtl/stamp_capture.sv
module stamp_capture
    import stamp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cap_in,
    output logic              irq
);
    logic [CNT_W-1:0]            cnt_q;
    logic [31:0]                 ctrl_q;
    logic [NEVT-1:0]             int_en_q;
    logic [NCAP-1:0][CNT_W-1:0]  cap_q;
    logic [NEVT-1:0]             flags;
    logic [NCAP-1:0]             pol;
    logic [NCAP-1:0]             cap_hit;
    logic [NEVT-1:0]             evt;
    logic                        wr, wr_cnt, rearm, run, ld_en, ovf_evt;
    logic                        rise, fall, fire, halted;
    logic [IDX_W-1:0]            idx;

    assign wr      = bus_sel && bus_we;
    assign wr_cnt  = wr && (bus_addr == OFS_CNT);
    assign rearm   = wr && (bus_addr == OFS_CTRL) && bus_wdata[CB_REARM];
    assign run     = ctrl_q[CB_RUN];
    assign ld_en   = ctrl_q[CB_LOAD];
    assign ovf_evt = run && !wr_cnt && (&cnt_q);

    generate
        for (genvar i = 0; i < NCAP; i++) begin : g_pol
            assign pol[i]     = ctrl_q[2*i];
            assign cap_hit[i] = fire && (idx == IDX_W'(i));
        end
    endgenerate

    assign evt = {ovf_evt, cap_hit};

    stamp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(rise), .fall(fall)
    );

    stamp_seq #(.N(NCAP), .IW(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .pol(pol),
        .ld_en(ld_en), .oneshot(ctrl_q[CB_ONESHOT]),
        .stop_idx(ctrl_q[CB_STOP_LO +: IDX_W]), .rearm(rearm),
        .fire(fire), .idx(idx), .halted(halted)
    );

    stamp_irq #(.NE(NEVT)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .en(int_en_q),
        .clr_flags((wr && bus_addr == OFS_CLR) ? bus_wdata[NEVT:1] : '0),
        .clr_glb(wr && bus_addr == OFS_CLR && bus_wdata[0]),
        .flags(flags), .irq(irq)
    );

    // counter, control and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ctrl_q   <= '0;
            int_en_q <= '0;
        end else begin
            if (wr_cnt)      cnt_q <= bus_wdata[CNT_W-1:0];
            else if (run)    cnt_q <= cnt_q + 1'b1;
            if (wr && bus_addr == OFS_CTRL) ctrl_q   <= bus_wdata & CTRL_MASK;
            if (wr && bus_addr == OFS_IEF)  int_en_q <= bus_wdata[EN_LO +: NEVT];
        end
    end

    // capture slots: an input capture wins over a software write
    generate
        for (genvar i = 0; i < NCAP; i++) begin : g_cap
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cap_q[i] <= '0;
                else if (cap_hit[i])
                    cap_q[i] <= cnt_q;
                else if (wr && bus_addr == OFS_CAP0 + ADDR_W'(4*i))
                    cap_q[i] <= bus_wdata[CNT_W-1:0];
            end
        end
    endgenerate

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == OFS_CNT)  bus_rdata = 32'(cnt_q);
            if (bus_addr == OFS_CTRL) bus_rdata = ctrl_q;
            if (bus_addr == OFS_IEF)
                bus_rdata = (32'(flags) << FLAG_LO) | (32'(int_en_q) << EN_LO);
            for (int i = 0; i < NCAP; i++)
                if (bus_addr == OFS_CAP0 + ADDR_W'(4*i)) bus_rdata = 32'(cap_q[i]);
        end
    end
endmodule

// File: rtl/stamp_chk.sv
module stamp_chk
    import stamp_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [CNT_W-1:0]           cnt_q,
    input logic [31:0]                ctrl_q,
    input logic [NCAP-1:0][CNT_W-1:0] cap_q,
    input logic [NEVT-1:0]            flags,
    input logic                       halted,
    input logic                       irq
);
    logic bus_wr, cnt_wr, clr_wr;
    assign bus_wr = bus_sel && bus_we;
    assign cnt_wr = bus_wr && (bus_addr == OFS_CNT);
    assign clr_wr = bus_wr && (bus_addr == OFS_CLR);

    // R1
    cnt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_RUN] && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CB_RUN] && !cnt_wr) |=> $stable(cnt_q));

    // R2
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_RUN] && !cnt_wr && (&cnt_q)) |=> flags[NCAP]);

    // R5
    no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CB_LOAD] && !bus_wr) |=> $stable(cap_q));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !bus_wr) |=> $stable(cap_q));

    // R9
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (($past(flags) & ~flags) == '0));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (flags != '0));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(clr_wr && bus_wdata[0])) |=> irq);
endmodule

bind stamp_capture stamp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q),
    .ctrl_q(ctrl_q), .cap_q(cap_q), .flags(flags), .halted(halted), .irq(irq)
);

// File: tb/sim_stamp_capture.sv
`timescale 1ns/1ps
module sim_stamp_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_in = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];
    item_t cur;

    always #10 clk = ~clk;   // 50 MHz

    stamp_capture u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .irq(irq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // driver: push the expected item, then issue the read
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    // monitor: compare read data mid-cycle
    always @(negedge clk) begin
        if (bus_sel && !bus_we && sbq.size() > 0) begin
            cur = sbq.pop_front();
            checks++;
            if (bus_rdata !== cur.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", cur.tag, bus_rdata, cur.exp);
            end
        end
    end

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    task automatic edge_to(input logic v);
        @(posedge clk); #1 cap_in = v;
        repeat (5) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state and unmapped reads
        rd(8'h00, 32'h0, "R11 counter after reset");
        rd(8'h28, 32'h0, "R11 control after reset");
        rd(8'h40, 32'h0, "R11 unmapped 0x40");
        rd(8'h04, 32'h0, "R11 unmapped 0x04");
        chk_irq(1'b0, "R11 irq after reset");

        // R1 counting from a written value
        wr(8'h00, 32'd1000);
        wr(8'h28, 32'h0010_0000);
        rd(8'h00, 32'd1001, "R1 count +1");
        rd(8'h00, 32'd1003, "R1 count +3");

        // R2 wrap event with its enable set
        wr(8'h28, 32'h0);
        wr(8'h2C, 32'h20);
        wr(8'h00, 32'hFFFF_FFFE);
        wr(8'h28, 32'h0010_0000);
        repeat (4) @(posedge clk);
        wr(8'h28, 32'h0);
        rd(8'h2C, 32'h0020_0020, "R2 wrap flag bit 21");
        chk_irq(1'b1, "R2 irq from wrap");
        wr(8'h30, 32'h21);
        rd(8'h2C, 32'h20, "R9 wrap flag cleared");
        chk_irq(1'b0, "R9 latch cleared");
        wr(8'h2C, 32'h0);

        // R3 R6 continuous rotation, slots 1 and 3 on falling edges
        wr(8'h28, 32'h0006_0144);
        wr(8'h00, 32'd10); edge_to(1'b1);
        wr(8'h00, 32'd20); edge_to(1'b0);
        wr(8'h00, 32'd30); edge_to(1'b1);
        wr(8'h00, 32'd40); edge_to(1'b0);
        wr(8'h00, 32'd50); edge_to(1'b1);
        rd(8'h08, 32'd50, "R6 slot 0 after wrap");
        rd(8'h0C, 32'd20, "R3 slot 1");
        rd(8'h10, 32'd30, "R3 slot 2");
        rd(8'h14, 32'd40, "R3 slot 3");

        // R4 slot 1 switched to rising: falling edge ignored
        wr(8'h28, 32'h0006_0140);
        wr(8'h00, 32'd60); edge_to(1'b0);
        rd(8'h0C, 32'd20, "R4 opposite edge ignored");
        wr(8'h00, 32'd70); edge_to(1'b1);
        rd(8'h0C, 32'd70, "R4 selected edge loads");

        // R5 load disabled
        wr(8'h28, 32'h0006_0040);
        wr(8'h00, 32'd80); edge_to(1'b0); edge_to(1'b1);
        rd(8'h10, 32'd30, "R5 no load when disabled");

        // R7 one-shot, stop index 1, re-arm
        wr(8'h28, 32'h000B_0100);
        rd(8'h28, 32'h0003_0100, "R7 rearm bit reads 0");
        edge_to(1'b0);
        wr(8'h00, 32'd100); edge_to(1'b1); edge_to(1'b0);
        wr(8'h00, 32'd110); edge_to(1'b1); edge_to(1'b0);
        wr(8'h00, 32'd120); edge_to(1'b1);
        rd(8'h08, 32'd100, "R7 halted slot 0 kept");
        rd(8'h0C, 32'd110, "R7 stop slot loaded");
        wr(8'h28, 32'h000B_0100);
        edge_to(1'b0);
        wr(8'h00, 32'd130); edge_to(1'b1);
        rd(8'h08, 32'd130, "R7 rearm restarts at slot 0");

        // R12 software write of a slot
        wr(8'h14, 32'hDEAD_BEEF);
        rd(8'h14, 32'hDEAD_BEEF, "R12 slot write");

        // R8 R10 flags, enables and latch
        chk_irq(1'b0, "R10 unenabled flags raise nothing");
        wr(8'h30, 32'h1E);
        rd(8'h2C, 32'h0, "R9 capture flags cleared");
        wr(8'h2C, 32'h02);
        rd(8'h2C, 32'h02, "R8 enable readback");
        wr(8'h28, 32'h000B_0100);
        edge_to(1'b0);
        wr(8'h00, 32'd140); edge_to(1'b1);
        chk_irq(1'b1, "R10 enabled flag sets latch");
        rd(8'h2C, 32'h0002_0002, "R8 flag bit 17");
        wr(8'h30, 32'h02);
        rd(8'h2C, 32'h02, "R9 flag only cleared");
        chk_irq(1'b1, "R10 latch survives flag clear");
        wr(8'h30, 32'h01);
        chk_irq(1'b0, "R9 latch clear");

        // R9 clear lands on the capture edge: set wins
        wr(8'h28, 32'h000B_0100);
        edge_to(1'b0);
        wr(8'h00, 32'd150);
        @(posedge clk); #1 cap_in = 1'b1;
        @(posedge clk);
        wr(8'h30, 32'h03);
        repeat (3) @(posedge clk);
        #1;
        chk_irq(1'b1, "R9 latch set wins over clear");
        rd(8'h2C, 32'h0002_0002, "R9 flag set wins over clear");
        rd(8'h08, 32'd150, "R3 slot 0 loaded in collision");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule